// File: doc/BRIEF.md
# I2C Receiver Acknowledge and Clock-Stretch Engine

This block runs the acknowledge phase of an I2C receiver. It works in the controller role and in the target role. It synchronizes the SCL line into the core clock domain and counts SCL falling edges within each 9-clock frame. From that count it decides whether to pull SDA low during the acknowledge clock. The choice comes from a software-controlled acknowledge bit: 0 gives an ACK and 1 gives a NACK. An abort request forces that bit to 1, and software writes to the bit are dropped while the abort lasts.

Clock stretching is optional. When it is enabled, the engine holds SCL low from a selectable frame position until software pulses a release strobe. The hold can start after the eighth falling edge, before the acknowledge bit, so that software can choose ACK or NACK. It can also start after the ninth falling edge, once the acknowledge has been sent. Byte shifting, address matching and arbitration belong to neighbouring logic. Those neighbours supply bus START and STOP indications as one-cycle pulses.

The controller is a three-state machine:
- `ST_IDLE`: no transfer.
- `ST_BYTE`: counting clocks in a frame.
- `ST_HOLD`: SCL is held low.

The transitions are:
- `ST_IDLE`→`ST_BYTE` on START.
- `ST_BYTE`→`ST_BYTE` on repeated START, which clears the count.
- `ST_BYTE`→`ST_HOLD` on the falling edge at the stretch point when stretching is enabled.
- `ST_HOLD`→`ST_BYTE` on the release strobe or on START.
- `ST_BYTE`→`ST_IDLE` and `ST_HOLD`→`ST_IDLE` on STOP.

START takes priority over STOP, and STOP takes priority over release.

Top module: `i2c_ack_stretch`

## Requirements
- R1: After reset, `scl_pd`, `sda_pd` and `stretch_active` are 0, `ack_sel` is 0, and the engine is idle.
- R2: `scl_in` passes through a two-flop synchronizer. An SCL falling edge applied just after a clock edge first affects the outputs at the third rising `clk` edge.
- R3: A `bus_start` pulse clears the frame count to 0 from any state and ends any hold. Falling edges then count 1 to 9, and the tenth wraps to 1.
- R4: From the 8th falling edge of a frame until the 9th, `sda_pd` equals the inverse of `ack_sel`. At all other times `sda_pd` is 0.
- R5: While `ack_sel` is 1 (NACK), `sda_pd` stays 0.
- R6: With stretching enabled, `stretch_at8`=1 makes `scl_pd` and `stretch_active` rise after the 8th falling edge, and `stretch_at8`=0 makes them rise after the 9th.
- R7: With `stretch_en`=0, `scl_pd` is never asserted, whatever `stretch_at8` is.
- R8: A `release_stb` pulse during a hold clears `scl_pd` and `stretch_active` at the next edge. The frame count is kept.
- R9: `abort_req` sets `ack_sel` to 1 at the next edge. An `ack_wr` while `abort_req` is 1 is discarded.
- R10: When there is no abort, `ack_wr` loads `ack_wdata` into `ack_sel` at the next edge. Otherwise `ack_sel` keeps its value.
- R11: `bus_stop` returns the engine to idle. Both pull-downs are released, and SCL falling edges are ignored until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| bus_start | input | 1 | One-cycle START / repeated START indication |
| bus_stop | input | 1 | One-cycle STOP indication |
| ack_wr | input | 1 | Software write strobe for the acknowledge bit |
| ack_wdata | input | 1 | Value written to the acknowledge bit (1 = NACK) |
| stretch_en | input | 1 | Clock stretching enable |
| stretch_at8 | input | 1 | Stretch point: 1 = after 8th fall, 0 = after 9th fall |
| abort_req | input | 1 | Abort in progress; forces NACK |
| release_stb | input | 1 | Software pulse ending a stretch |
| scl_pd | output | 1 | SCL open-drain pull-down enable |
| sda_pd | output | 1 | SDA open-drain pull-down enable |
| stretch_active | output | 1 | Stretch in progress, interrupt source |
| ack_sel | output | 1 | Current acknowledge bit (1 = NACK) |

## Verification
A wrong frame count becomes visible at the pins within one SCL clock. Either `sda_pd` asserts on the wrong bit, or `scl_pd` rises at the wrong falling edge. Both can be seen three core cycles after the offending SCL edge. A state machine stuck in `ST_HOLD` shows up as `scl_pd` still high one cycle after a release strobe. A stale acknowledge register shows up through `ack_sel` one cycle after a write or an abort. It also shows up through `sda_pd` in the next acknowledge window. The sweep visits every combination of acknowledge value, stretch enable and stretch point, over two back-to-back frames, so any off-by-one in the wrap or in the stretch point is caught.

// File: rtl/i2c_ase_pkg.sv
package i2c_ase_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BYTE = 2'd1,
        ST_HOLD = 2'd2
    } ase_state_t;

    localparam int FRAME_BITS = 9;
endpackage

// File: rtl/i2c_ase_sync.sv
module i2c_ase_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[g] <= RESET_VAL;
                end else begin
                    chain[g] <= (g == 0) ? d : chain[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_ase_bitcnt.sv
module i2c_ase_bitcnt #(
    parameter int FRAME = 9,
    parameter int CW    = $clog2(FRAME + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic          fall,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] LAST = CW'(FRAME);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (run && fall) begin
            cnt <= (cnt == LAST) ? CW'(1) : cnt + CW'(1);
        end
    end

    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    p_clr_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && run && fall && cnt == LAST) |=> (cnt == CW'(1)));
endmodule

// File: rtl/i2c_ase_ackreg.sv
module i2c_ase_ackreg (
    input  logic clk,
    input  logic rst_n,
    input  logic abort_req,
    input  logic wr,
    input  logic wdata,
    output logic ack_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
        end else if (abort_req) begin
            ack_q <= 1'b1;
        end else if (wr) begin
            ack_q <= wdata;
        end
    end

    p_abort_nack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> ack_q);
    p_write_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!abort_req && wr) |=> (ack_q == $past(wdata)));
    p_hold_value_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!abort_req && !wr) |=> $stable(ack_q));
endmodule

// File: rtl/i2c_ack_stretch.sv
module i2c_ack_stretch
    import i2c_ase_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FRAME       = FRAME_BITS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic bus_start,
    input  logic bus_stop,
    input  logic ack_wr,
    input  logic ack_wdata,
    input  logic stretch_en,
    input  logic stretch_at8,
    input  logic abort_req,
    input  logic release_stb,
    output logic scl_pd,
    output logic sda_pd,
    output logic stretch_active,
    output logic ack_sel
);
    localparam int              CW      = $clog2(FRAME + 1);
    localparam logic [CW-1:0]   ACK_CNT = CW'(FRAME - 1);
    localparam logic [CW-1:0]   PRE_8   = CW'(FRAME - 2);
    localparam logic [CW-1:0]   PRE_9   = CW'(FRAME - 1);
    localparam logic [CW-1:0]   LAST    = CW'(FRAME);

    ase_state_t    state, state_nxt;
    logic          scl_s, scl_d, fall;
    logic [CW-1:0] cnt;
    logic          at_point;

    i2c_ase_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_scl_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (scl_in),
        .q     (scl_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) scl_d <= 1'b1;
        else        scl_d <= scl_s;
    end

    assign fall = scl_d & ~scl_s;

    i2c_ase_bitcnt #(.FRAME(FRAME), .CW(CW)) u_bitcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (bus_start | bus_stop),
        .run   (state == ST_BYTE),
        .fall  (fall),
        .cnt   (cnt)
    );

    i2c_ase_ackreg u_ackreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort_req (abort_req),
        .wr        (ack_wr),
        .wdata     (ack_wdata),
        .ack_q     (ack_sel)
    );

    assign at_point = fall && (cnt == (stretch_at8 ? PRE_8 : PRE_9));

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (bus_start) state_nxt = ST_BYTE;
            end
            ST_BYTE: begin
                if (bus_start)                  state_nxt = ST_BYTE;
                else if (bus_stop)              state_nxt = ST_IDLE;
                else if (stretch_en && at_point) state_nxt = ST_HOLD;
            end
            ST_HOLD: begin
                if (bus_start)        state_nxt = ST_BYTE;
                else if (bus_stop)    state_nxt = ST_IDLE;
                else if (release_stb) state_nxt = ST_BYTE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        scl_pd         = (state == ST_HOLD);
        stretch_active = (state == ST_HOLD);
        sda_pd         = (state != ST_IDLE) && (cnt == ACK_CNT) && !ack_sel;
    end

    p_hold_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pd) |-> $past(stretch_en));
    p_hold_point_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pd) |-> (cnt == ($past(stretch_at8) ? ACK_CNT : LAST)));
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_pd && release_stb && !bus_start && !bus_stop) |=> (!scl_pd && $stable(cnt)));
    p_nack_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_sel |-> !sda_pd);
    p_stop_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stop && !bus_start) |=> (!scl_pd && !sda_pd));
    p_start_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> !scl_pd);
endmodule

// File: tb/i2c_ack_stretch_tb.sv
module i2c_ack_stretch_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_in = 1'b1;
    logic bus_start = 1'b0, bus_stop = 1'b0;
    logic ack_wr = 1'b0, ack_wdata = 1'b0;
    logic stretch_en = 1'b0, stretch_at8 = 1'b0;
    logic abort_req = 1'b0, release_stb = 1'b0;
    logic scl_pd, sda_pd, stretch_active, ack_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_ack_stretch u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in),
        .bus_start(bus_start), .bus_stop(bus_stop),
        .ack_wr(ack_wr), .ack_wdata(ack_wdata),
        .stretch_en(stretch_en), .stretch_at8(stretch_at8),
        .abort_req(abort_req), .release_stb(release_stb),
        .scl_pd(scl_pd), .sda_pd(sda_pd),
        .stretch_active(stretch_active), .ack_sel(ack_sel)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic scl_fall();
        scl_in = 1'b1; tick(4);
        scl_in = 1'b0; tick(4);
    endtask

    task automatic pulse_start();
        bus_start = 1'b1; tick(1); bus_start = 1'b0;
    endtask

    task automatic pulse_stop();
        bus_stop = 1'b1; tick(1); bus_stop = 1'b0;
    endtask

    task automatic pulse_release();
        release_stb = 1'b1; tick(1); release_stb = 1'b0;
    endtask

    task automatic write_ack(input logic d);
        ack_wr = 1'b1; ack_wdata = d; tick(1); ack_wr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 scl_pd", scl_pd, 1'b0);
        chk("R1 sda_pd", sda_pd, 1'b0);
        chk("R1 stretch_active", stretch_active, 1'b0);
        chk("R1 ack_sel", ack_sel, 1'b0);

        // Sweep: ack value x stretch enable x stretch point, two frames each
        for (int combo = 0; combo < 8; combo++) begin
            logic a, en, s8;
            a = combo[0]; en = combo[1]; s8 = combo[2];
            write_ack(a);
            chk("R10 ack load", ack_sel, a);
            stretch_en = en; stretch_at8 = s8;
            pulse_start();
            for (int fr = 0; fr < 2; fr++) begin
                for (int k = 1; k <= 9; k++) begin
                    logic eh, es;
                    eh = en && (k == (s8 ? 8 : 9));
                    es = !a && (k == 8);
                    scl_fall();
                    chk(eh ? "R6 hold point" : "R7 no hold", scl_pd, eh);
                    chk("R6 stretch_active", stretch_active, eh);
                    chk(a ? "R5 nack quiet" : "R4 ack window", sda_pd, es);
                    if (eh) begin
                        pulse_release();
                        chk("R8 release scl", scl_pd, 1'b0);
                        chk("R8 release flag", stretch_active, 1'b0);
                        chk("R8 count kept", sda_pd, es);
                    end
                end
            end
            pulse_stop();
            chk("R11 stop scl", scl_pd, 1'b0);
            chk("R11 stop sda", sda_pd, 1'b0);
            for (int k = 1; k <= 9; k++) begin
                scl_fall();
                chk("R11 idle ignores scl", scl_pd | sda_pd, 1'b0);
            end
        end

        // R2 exact synchronizer latency
        write_ack(1'b1);
        stretch_en = 1'b1; stretch_at8 = 1'b1;
        pulse_start();
        for (int k = 1; k <= 7; k++) scl_fall();
        scl_in = 1'b1; tick(4);
        scl_in = 1'b0;
        tick(1); chk("R2 edge1", scl_pd, 1'b0);
        tick(1); chk("R2 edge2", scl_pd, 1'b0);
        tick(1); chk("R2 edge3", scl_pd, 1'b1);
        tick(2);

        // R3 START during hold clears count and hold
        pulse_start();
        chk("R3 start frees scl", scl_pd, 1'b0);
        stretch_at8 = 1'b0;
        for (int k = 1; k <= 9; k++) begin
            scl_fall();
            chk("R3 recount", scl_pd, k == 9);
        end
        pulse_release();
        pulse_stop();

        // R9 / R10 abort behaviour
        write_ack(1'b0);
        chk("R10 ack 0", ack_sel, 1'b0);
        abort_req = 1'b1; tick(1);
        chk("R9 abort forces nack", ack_sel, 1'b1);
        write_ack(1'b0);
        chk("R9 write discarded", ack_sel, 1'b1);
        stretch_en = 1'b0;
        pulse_start();
        for (int k = 1; k <= 8; k++) scl_fall();
        chk("R9 abort no sda", sda_pd, 1'b0);
        abort_req = 1'b0; tick(3);
        chk("R10 retains", ack_sel, 1'b1);
        write_ack(1'b0);
        chk("R10 write after abort", ack_sel, 1'b0);
        chk("R4 ack driven", sda_pd, 1'b1);
        scl_fall();
        chk("R4 window ends", sda_pd, 1'b0);
        pulse_stop();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule